// File: doc/BRIEF.md
# UTOPIA transmit cell capture

This block sits on the cell side of a transmit path and accepts ATM cells from an ATM layer device over a UTOPIA-style transmit bus. The bus has a data word, a start-of-cell strobe and an active-low transfer enable. A configuration bit sets the data word to 8 or 16 bits. The block counts the octets of each cell against the configured cell length. That length is 52 or 53 octets on the narrow bus and 52 or 54 octets on the wide bus. Every complete cell is committed to a small cell FIFO, and the FIFO is read out one octet at a time by the downstream framer.

The start-of-cell strobe sets the cell boundaries. A new start-of-cell that arrives before the current cell has reached its length turns the partial cell into a runt. The runt is dropped and a sticky alignment-change status bit is set. Data that arrives after a cell is complete and before the next start-of-cell is ignored. The flow-control output tells the ATM layer whether another complete cell fits. A cell that starts while the FIFO is full is dropped as a whole and counted as an overflow.

A small register interface holds the configuration and exposes the interrupt enable, the sticky status bit and the overflow count.

Top module: `utx_cell_capture`

## Requirements
- R1: After reset the configuration register reads 0x00. This means an 8-bit bus, a 53-octet cell and a one-cell FIFO. After reset, tx_clav is 1, cell_valid is 0 and align_irq is 0.
- R2: A cell begins on a beat (a cycle with tx_enb_n low) that has tx_soc high, and the octet on the data bus in that beat is the cell's first octet. With config bit 3 clear on an 8-bit bus, the cell is 53 octets taken from tx_data[7:0]. The cell is read out in arrival order, with cell_sop on the first octet and cell_eop on the last.
- R3: Once a cell has reached its length, beats without tx_soc are ignored and never reach the FIFO.
- R4: Cycles with tx_enb_n high neither advance nor restart the octet count, even when tx_soc is high.
- R5: Config bit 0 set selects the 16-bit bus. Each beat then carries two octets, tx_data[15:8] first and tx_data[7:0] second. With bit 3 clear a cell is 27 beats (54 octets). With bit 3 set it is 26 beats (52 octets).
- R6: Config bit 3 set with bit 0 clear gives a 52-octet cell on the 8-bit bus.
- R7: If tx_soc arrives on a beat before the current cell is complete, the partial cell never appears at the FIFO output. Status register (address 2) bit 0 is set, and the new cell is captured normally.
- R8: align_irq equals status bit 0 AND interrupt-enable bit 0 (address 1). Reading address 2 with reg_rd clears the status bit.
- R9: Config bits 2:1 hold the FIFO depth minus one, so the depth is 1 to 4 cells. tx_clav is 1 exactly while the committed cells plus any cell being captured number fewer than the depth.
- R10: A tx_soc beat while the committed cells fill the depth drops that whole cell and adds one to the saturating 8-bit overflow count at address 3. Cells already stored are unaffected.
- R11: Config register (address 0) bits 5:0 read back as written: bit 4 is the multi-PHY enable and bit 5 is the handshake mode. Bits 7:6 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_data | input | 16 | Transmit data word; only bits 7:0 are used on the 8-bit bus |
| tx_soc | input | 1 | Start of cell, high with the first word of a cell |
| tx_enb_n | input | 1 | Transfer enable, active low |
| tx_clav | output | 1 | Room for one more complete cell |
| reg_we | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status on address 2) |
| reg_addr | input | 2 | Register address: 0 config, 1 interrupt enable, 2 status, 3 overflow count |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| align_irq | output | 1 | Alignment-change interrupt, masked by the enable |
| cell_rd | input | 1 | Pops one octet when cell_valid is high |
| cell_valid | output | 1 | At least one complete cell is stored |
| cell_data | output | 8 | Octet at the head of the FIFO |
| cell_sop | output | 1 | Head octet is the first of its cell |
| cell_eop | output | 1 | Head octet is the last of its cell |

## Verification
The hardest case to reach is a start-of-cell that arrives while the FIFO is full. It needs several cells committed up to the programmed depth, with no reads, before the next strobe. The bench programs a depth of two, sends two complete cells without popping, and then sends a third. It then reads the overflow count and drains the FIFO to show that only the first two cells come out. The runt case is driven by cutting one cell off after 30 octets with a fresh strobe. The output must then show only the second cell.

// File: rtl/utx_pkg.sv
// Package: shared constants, types and the cell-length rule for the
// transmit cell capture block. Assumes cells of at most 54 octets.
package utx_pkg;

    localparam int OCT_W        = 6;   // width of an octet offset within a cell
    localparam int CELL_MAX_OCT = 54;  // largest cell the FIFO slot must hold

    localparam logic [1:0] REG_CFG   = 2'd0;
    localparam logic [1:0] REG_IRQEN = 2'd1;
    localparam logic [1:0] REG_STAT  = 2'd2;
    localparam logic [1:0] REG_OVF   = 2'd3;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_FILL = 2'd1,
        CAP_DROP = 2'd2
    } cap_state_t;

    // Configuration word, MSB first: handshake, multi-PHY, short cell, depth-1, wide bus
    typedef struct packed {
        logic       handshake;
        logic       mphy;
        logic       cell52;
        logic [1:0] depth_sel;
        logic       wide;
    } utx_cfg_t;

    // Octets per cell for a given size selection and bus width
    function automatic logic [OCT_W-1:0] cell_len(input logic cell52, input logic wide);
        if (cell52)
            return OCT_W'(52);
        else if (wide)
            return OCT_W'(54);
        else
            return OCT_W'(53);
    endfunction

endpackage

// File: rtl/utx_cfg_regs.sv
// Module: configuration and status registers.
// Holds the configuration word, the interrupt enable, the sticky
// alignment-change bit (set has priority over clear-on-read) and a
// saturating overflow counter. Read data is combinational.
module utx_cfg_regs
    import utx_pkg::*;
#(
    parameter int OVF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic             align_evt,
    input  logic             ovf_evt,
    output utx_cfg_t         cfg,
    output logic [7:0]       reg_rdata,
    output logic             align_sticky,
    output logic [OVF_W-1:0] ovf_cnt,
    output logic             align_irq
);

    localparam logic [OVF_W-1:0] OVF_MAX = {OVF_W{1'b1}};

    utx_cfg_t         cfg_q;
    logic             irq_en_q;
    logic             align_q;
    logic [OVF_W-1:0] ovf_q;

    // Configuration and interrupt enable writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            irq_en_q <= 1'b0;
        end else if (reg_we) begin
            if (reg_addr == REG_CFG)
                cfg_q <= utx_cfg_t'(reg_wdata[5:0]);
            if (reg_addr == REG_IRQEN)
                irq_en_q <= reg_wdata[0];
        end
    end

    // Sticky alignment-change bit: a new event wins over a clearing read
    always_ff @(posedge clk) begin
        if (!rst_n)
            align_q <= 1'b0;
        else if (align_evt)
            align_q <= 1'b1;
        else if (reg_rd && reg_addr == REG_STAT)
            align_q <= 1'b0;
    end

    // Saturating count of cells dropped for lack of FIFO room
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= '0;
        else if (ovf_evt && ovf_q != OVF_MAX)
            ovf_q <= ovf_q + 1'b1;
    end

    // Read multiplexer
    always_comb begin
        reg_rdata = 8'h00;
        case (reg_addr)
            REG_CFG:   reg_rdata = {2'b00, cfg_q};
            REG_IRQEN: reg_rdata = {7'b0, irq_en_q};
            REG_STAT:  reg_rdata = {7'b0, align_q};
            default:   reg_rdata = 8'(ovf_q);
        endcase
    end

    assign cfg          = cfg_q;
    assign align_sticky = align_q;
    assign ovf_cnt      = ovf_q;
    assign align_irq    = align_q & irq_en_q;

endmodule

// File: rtl/utx_cell_framer.sv
// Module: cell boundary tracker for the transmit bus.
// Counts octets per beat against the cell length latched at start-of-cell.
// It emits per-lane octet writes into the staging slot, a commit when the
// cell completes, and the runt and overflow events. Assumes cell lengths
// of at least 52, so no cell ends on its own start beat.
module utx_cell_framer
    import utx_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LANES*8-1:0]          tx_data,
    input  logic                        tx_soc,
    input  logic                        tx_enb_n,
    input  logic                        cfg_wide,
    input  logic                        cfg_cell52,
    input  logic                        slot_free,
    output logic [LANES-1:0]            wr_en,
    output logic [LANES-1:0][OCT_W-1:0] wr_off,
    output logic [LANES-1:0][7:0]       wr_byte,
    output logic                        commit,
    output logic [OCT_W-1:0]            commit_len,
    output logic                        filling,
    output logic                        align_evt,
    output logic                        ovf_evt
);

    cap_state_t       st_q;
    logic [OCT_W-1:0] cnt_q;
    logic [OCT_W-1:0] len_q;
    logic             wide_q;

    logic             beat;
    logic             start;
    logic             wide_eff;
    logic             do_write;
    logic [OCT_W-1:0] n_oct;
    logic [OCT_W-1:0] base_off;
    logic [OCT_W-1:0] next_cnt;

    // Beat decode and octet arithmetic for the current cycle
    always_comb begin
        beat     = !tx_enb_n;
        start    = beat && tx_soc;
        wide_eff = start ? cfg_wide : wide_q;
        n_oct    = wide_eff ? OCT_W'(LANES) : OCT_W'(1);
        base_off = start ? '0 : cnt_q;
        next_cnt = base_off + n_oct;
        do_write = beat && (start ? slot_free : (st_q == CAP_FILL));
    end

    // Per-lane octet placement: on the wide bus the upper byte comes first
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wr_en[g]   = do_write && ((g == 0) || wide_eff);
        assign wr_off[g]  = base_off + OCT_W'(g);
        assign wr_byte[g] = wide_eff ? tx_data[(LANES-1-g)*8 +: 8]
                                     : ((g == 0) ? tx_data[7:0] : 8'h00);
    end

    assign align_evt  = start && (st_q != CAP_IDLE);
    assign ovf_evt    = start && !slot_free;
    assign commit     = beat && !tx_soc && (st_q == CAP_FILL) && (next_cnt >= len_q);
    assign commit_len = len_q;
    assign filling    = (st_q == CAP_FILL);

    // Cell state: start, advance, finish (dropped cells are counted out too)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= CAP_IDLE;
            cnt_q  <= '0;
            len_q  <= cell_len(1'b0, 1'b0);
            wide_q <= 1'b0;
        end else if (start) begin
            st_q   <= slot_free ? CAP_FILL : CAP_DROP;
            cnt_q  <= n_oct;
            len_q  <= cell_len(cfg_cell52, cfg_wide);
            wide_q <= cfg_wide;
        end else if (beat && st_q != CAP_IDLE) begin
            if (next_cnt >= len_q) begin
                st_q  <= CAP_IDLE;
                cnt_q <= '0;
            end else begin
                cnt_q <= next_cnt;
            end
        end
    end

endmodule

// File: rtl/utx_cell_fifo.sv
// Module: slot-based cell FIFO.
// Each slot holds one cell. Octets are written into the slot at the write
// pointer while the cell is captured, and become visible only on commit, so
// an abandoned runt is simply overwritten. The read side pops one octet at a time.
module utx_cell_fifo
    import utx_pkg::*;
#(
    parameter int MAX_CELLS = 4,
    parameter int LANES     = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [LANES-1:0]                    wr_en,
    input  logic [LANES-1:0][OCT_W-1:0]         wr_off,
    input  logic [LANES-1:0][7:0]               wr_byte,
    input  logic                                commit,
    input  logic [OCT_W-1:0]                    commit_len,
    input  logic [$clog2(MAX_CELLS+1)-1:0]      depth,
    input  logic                                rd_en,
    output logic                                slot_free,
    output logic [$clog2(MAX_CELLS+1)-1:0]      cell_count,
    output logic                                rd_valid,
    output logic [7:0]                          rd_data,
    output logic                                rd_sop,
    output logic                                rd_eop
);

    localparam int SLOT_W = (MAX_CELLS > 1) ? $clog2(MAX_CELLS) : 1;
    localparam int CNT_W  = $clog2(MAX_CELLS + 1);
    localparam int WORDS  = MAX_CELLS * CELL_MAX_OCT;
    localparam int ADDR_W = $clog2(WORDS);

    logic [7:0]        mem_q [WORDS];
    logic [OCT_W-1:0]  len_q [MAX_CELLS];
    logic [SLOT_W-1:0] wr_slot_q;
    logic [SLOT_W-1:0] rd_slot_q;
    logic [OCT_W-1:0]  rd_idx_q;
    logic [CNT_W-1:0]  count_q;

    logic [LANES-1:0][ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0]            rd_addr;
    logic                         pop;
    logic                         pop_last;

    // Advance a slot pointer with wrap at the slot count
    function automatic logic [SLOT_W-1:0] slot_next(input logic [SLOT_W-1:0] s);
        return (int'(s) == MAX_CELLS - 1) ? '0 : s + 1'b1;
    endfunction

    // Octet addresses within the flat storage
    always_comb begin
        for (int g = 0; g < LANES; g++)
            wr_addr[g] = ADDR_W'(int'(wr_slot_q) * CELL_MAX_OCT + int'(wr_off[g]));
        rd_addr = ADDR_W'(int'(rd_slot_q) * CELL_MAX_OCT + int'(rd_idx_q));
    end

    // Octet storage and per-slot length (data path, not reset)
    always_ff @(posedge clk) begin
        for (int g = 0; g < LANES; g++)
            if (wr_en[g])
                mem_q[wr_addr[g]] <= wr_byte[g];
        if (commit)
            len_q[wr_slot_q] <= commit_len;
    end

    assign rd_valid = (count_q != '0);
    assign rd_data  = mem_q[rd_addr];
    assign rd_sop   = (rd_idx_q == '0);
    assign rd_eop   = (rd_idx_q == len_q[rd_slot_q] - 1'b1);
    assign pop      = rd_en && rd_valid;
    assign pop_last = pop && rd_eop;

    // Write pointer moves on commit; the staging slot is the one it names
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_slot_q <= '0;
        else if (commit)
            wr_slot_q <= slot_next(wr_slot_q);
    end

    // Read pointer and octet index within the head cell
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_slot_q <= '0;
            rd_idx_q  <= '0;
        end else if (pop_last) begin
            rd_slot_q <= slot_next(rd_slot_q);
            rd_idx_q  <= '0;
        end else if (pop) begin
            rd_idx_q  <= rd_idx_q + 1'b1;
        end
    end

    // Committed cell count
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (commit && !pop_last)
            count_q <= count_q + 1'b1;
        else if (!commit && pop_last)
            count_q <= count_q - 1'b1;
    end

    assign slot_free  = (count_q < depth);
    assign cell_count = count_q;

endmodule

// File: rtl/utx_cell_capture.sv
// Module: top of the transmit cell capture block.
// Joins the register file, the boundary tracker and the cell FIFO, and
// derives the effective depth and the cell-available flow-control output.
// Assumes a single clock and a synchronous active-low reset.
module utx_cell_capture
    import utx_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int MAX_CELLS = 4,
    parameter int OVF_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_soc,
    input  logic              tx_enb_n,
    output logic              tx_clav,
    input  logic              reg_we,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              align_irq,
    input  logic              cell_rd,
    output logic              cell_valid,
    output logic [7:0]        cell_data,
    output logic              cell_sop,
    output logic              cell_eop
);

    localparam int LANES = DATA_W / 8;
    localparam int CNT_W = $clog2(MAX_CELLS + 1);

    utx_cfg_t                    cfg;
    logic                        align_sticky;
    logic [OVF_W-1:0]            ovf_cnt;
    logic [LANES-1:0]            wr_en;
    logic [LANES-1:0][OCT_W-1:0] wr_off;
    logic [LANES-1:0][7:0]       wr_byte;
    logic                        fr_commit;
    logic [OCT_W-1:0]            commit_len;
    logic                        filling;
    logic                        align_evt;
    logic                        ovf_evt;
    logic                        slot_free;
    logic [CNT_W-1:0]            cell_count;
    logic [CNT_W-1:0]            depth_eff;

    // Depth from the two-bit field, limited to the slots built
    always_comb begin
        int d;
        d = int'(cfg.depth_sel) + 1;
        if (d > MAX_CELLS)
            d = MAX_CELLS;
        depth_eff = CNT_W'(d);
    end

    // Room for one more whole cell counts the one being captured
    assign tx_clav = ({1'b0, cell_count} + {{CNT_W{1'b0}}, filling}) < {1'b0, depth_eff};

    utx_cfg_regs #(
        .OVF_W (OVF_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_rd       (reg_rd),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .align_evt    (align_evt),
        .ovf_evt      (ovf_evt),
        .cfg          (cfg),
        .reg_rdata    (reg_rdata),
        .align_sticky (align_sticky),
        .ovf_cnt      (ovf_cnt),
        .align_irq    (align_irq)
    );

    utx_cell_framer #(
        .LANES (LANES)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_data    (tx_data),
        .tx_soc     (tx_soc),
        .tx_enb_n   (tx_enb_n),
        .cfg_wide   (cfg.wide),
        .cfg_cell52 (cfg.cell52),
        .slot_free  (slot_free),
        .wr_en      (wr_en),
        .wr_off     (wr_off),
        .wr_byte    (wr_byte),
        .commit     (fr_commit),
        .commit_len (commit_len),
        .filling    (filling),
        .align_evt  (align_evt),
        .ovf_evt    (ovf_evt)
    );

    utx_cell_fifo #(
        .MAX_CELLS (MAX_CELLS),
        .LANES     (LANES)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_off     (wr_off),
        .wr_byte    (wr_byte),
        .commit     (fr_commit),
        .commit_len (commit_len),
        .depth      (depth_eff),
        .rd_en      (cell_rd),
        .slot_free  (slot_free),
        .cell_count (cell_count),
        .rd_valid   (cell_valid),
        .rd_data    (cell_data),
        .rd_sop     (cell_sop),
        .rd_eop     (cell_eop)
    );

endmodule

// File: rtl/utx_cell_capture_chk.sv
// Module: property checker for the transmit cell capture block, bound
// to the top. Observes ports and signals between the submodules.
module utx_cell_capture_chk #(
    parameter int MAX_CELLS = 4,
    parameter int OVF_W     = 8,
    parameter int CNT_W     = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_soc,
    input logic             tx_enb_n,
    input logic             tx_clav,
    input logic             commit,
    input logic             align_sticky,
    input logic [OVF_W-1:0] ovf_cnt,
    input logic [CNT_W-1:0] cell_count,
    input logic [CNT_W-1:0] depth_eff,
    input logic [1:0]       reg_addr,
    input logic [7:0]       reg_rdata
);

    // A cell completes only on an enabled beat that is not a new start
    assert_commit_on_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (!tx_enb_n && !tx_soc));

    // The sticky runt flag rises only after an enabled start-of-cell
    assert_runt_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(align_sticky) |-> $past(tx_soc && !tx_enb_n));

    // Flow control is low whenever the committed cells fill the depth
    assert_clav_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_count >= depth_eff) |-> !tx_clav);

    // The FIFO never holds more cells than it has slots
    assert_fifo_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cell_count) <= MAX_CELLS);

    // A start while full bumps the overflow count by one
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_soc && !tx_enb_n && cell_count >= depth_eff && ovf_cnt != {OVF_W{1'b1}})
        |=> (ovf_cnt == $past(ovf_cnt) + 1'b1));

    // The overflow count never goes down
    assert_ovf_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ovf_cnt >= $past(ovf_cnt)));

    // Unused configuration bits read as zero
    assert_cfg_unused_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (reg_rdata[7:6] == 2'b00));

endmodule

bind utx_cell_capture utx_cell_capture_chk #(
    .MAX_CELLS (MAX_CELLS),
    .OVF_W     (OVF_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_soc       (tx_soc),
    .tx_enb_n     (tx_enb_n),
    .tx_clav      (tx_clav),
    .commit       (fr_commit),
    .align_sticky (align_sticky),
    .ovf_cnt      (ovf_cnt),
    .cell_count   (cell_count),
    .depth_eff    (depth_eff),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata)
);

// File: tb/utx_cell_capture_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module utx_cell_capture_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_soc = 1'b0;
    logic        tx_enb_n = 1'b1;
    logic        tx_clav;
    logic        reg_we = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        align_irq;
    logic        cell_rd = 1'b0;
    logic        cell_valid;
    logic [7:0]  cell_data;
    logic        cell_sop;
    logic        cell_eop;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    utx_cell_capture u_dut (
        .clk (clk), .rst_n (rst_n),
        .tx_data (tx_data), .tx_soc (tx_soc), .tx_enb_n (tx_enb_n), .tx_clav (tx_clav),
        .reg_we (reg_we), .reg_rd (reg_rd), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .align_irq (align_irq),
        .cell_rd (cell_rd), .cell_valid (cell_valid), .cell_data (cell_data),
        .cell_sop (cell_sop), .cell_eop (cell_eop)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic beat(input logic soc, input logic [15:0] d, input logic enb_n);
        @(negedge clk);
        tx_soc = soc; tx_data = d; tx_enb_n = enb_n;
    endtask

    task automatic idle();
        beat(1'b0, 16'h0000, 1'b1);
    endtask

    // Beats first..n-1 of a cell; octet k of the cell carries base+k
    task automatic send_cell(input int first, input int n, input logic wide,
                             input logic [7:0] base, input bit gaps);
        for (int j = first; j < n; j++) begin
            if (gaps && j == 5) begin
                beat(1'b1, 16'hDEAD, 1'b1);  // strobe with enable high: no effect
                beat(1'b0, 16'hBEEF, 1'b1);
            end
            if (wide)
                beat(j == 0, {base + 8'(2*j), base + 8'(2*j+1)}, 1'b0);
            else
                beat(j == 0, {8'hEE, base + 8'(j)}, 1'b0);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Pop one cell and compare every octet and its markers
    task automatic drain(input string req, input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0 || i == n - 1) begin
                chk(req, "cell_valid", cell_valid, 1);
                chk(req, "cell_sop", cell_sop, i == 0);
                chk(req, "cell_eop", cell_eop, i == n - 1);
            end
            if (cell_data !== base + 8'(i) || cell_valid !== 1'b1) begin
                chk(req, $sformatf("octet %0d", i), {cell_valid, cell_data}, {1'b1, base + 8'(i)});
            end
            cell_rd = 1'b1;
        end
        @(negedge clk);
        cell_rd = 1'b0;
        checks++;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        @(negedge clk);
        chk("R1", "tx_clav", tx_clav, 1);
        chk("R1", "cell_valid", cell_valid, 0);
        chk("R1", "align_irq", align_irq, 0);
        reg_read(2'd0, v);
        chk("R1", "config", v, 8'h00);
    endtask

    task automatic t_cfg_readback();
        logic [7:0] v;
        reg_write(2'd0, 8'hFF);
        reg_read(2'd0, v);
        chk("R11", "config readback", v, 8'h3F);
        reg_write(2'd0, 8'h30);
        reg_read(2'd0, v);
        chk("R11", "mphy/handshake bits", v, 8'h30);
        reg_write(2'd0, 8'h00);
    endtask

    task automatic t_basic53();
        // first beat, then check that the in-flight cell holds the only slot
        beat(1'b1, {8'hEE, 8'h00}, 1'b0);
        idle();
        chk("R9", "clav low while capturing", tx_clav, 0);
        send_cell(1, 53, 1'b0, 8'h00, 1'b1);
        for (int k = 0; k < 4; k++)
            beat(1'b0, {8'hEE, 8'hA5}, 1'b0);  // after cell end: ignored (R3)
        idle();
        chk("R2", "cell_valid after 53 octets", cell_valid, 1);
        chk("R9", "clav low with one cell, depth 1", tx_clav, 0);
        drain("R2", 53, 8'h00);
        chk("R3", "no extra cell from trailing beats", cell_valid, 0);
        chk("R4", "clav back high", tx_clav, 1);
    endtask

    task automatic t_cell52_narrow();
        reg_write(2'd0, 8'h08);
        send_cell(0, 51, 1'b0, 8'h60, 1'b0);
        idle();
        chk("R6", "not complete at 51 octets", cell_valid, 0);
        send_cell(51, 52, 1'b0, 8'h60, 1'b0);
        idle();
        chk("R6", "complete at 52 octets", cell_valid, 1);
        drain("R6", 52, 8'h60);
        chk("R6", "single cell", cell_valid, 0);
    endtask

    task automatic t_wide();
        reg_write(2'd0, 8'h01);
        send_cell(0, 27, 1'b1, 8'h40, 1'b1);
        idle();
        chk("R5", "54-octet wide cell ready", cell_valid, 1);
        drain("R5", 54, 8'h40);
        reg_write(2'd0, 8'h09);
        send_cell(0, 26, 1'b1, 8'hC0, 1'b0);
        idle();
        chk("R5", "52-octet wide cell ready", cell_valid, 1);
        drain("R5", 52, 8'hC0);
        chk("R5", "empty after wide cells", cell_valid, 0);
        reg_write(2'd0, 8'h00);
    endtask

    task automatic t_runt();
        logic [7:0] v;
        send_cell(0, 30, 1'b0, 8'h10, 1'b0);
        send_cell(0, 53, 1'b0, 8'h80, 1'b0);
        idle();
        chk("R8", "irq masked while disabled", align_irq, 0);
        reg_write(2'd1, 8'h01);
        chk("R8", "irq with enable", align_irq, 1);
        reg_read(2'd2, v);
        chk("R7", "status bit set", v, 8'h01);
        chk("R8", "irq cleared by read", align_irq, 0);
        reg_read(2'd2, v);
        chk("R8", "status cleared", v, 8'h00);
        drain("R7", 53, 8'h80);
        chk("R7", "runt never visible", cell_valid, 0);
    endtask

    task automatic t_depth_overflow();
        logic [7:0] v;
        reg_write(2'd0, 8'h02);
        send_cell(0, 53, 1'b0, 8'h20, 1'b0);
        idle();
        chk("R9", "clav high with 1 of 2", tx_clav, 1);
        send_cell(0, 53, 1'b0, 8'h50, 1'b0);
        idle();
        chk("R9", "clav low with 2 of 2", tx_clav, 0);
        reg_read(2'd3, v);
        chk("R10", "overflow count before", v, 8'h00);
        send_cell(0, 53, 1'b0, 8'h90, 1'b0);
        idle();
        reg_read(2'd3, v);
        chk("R10", "overflow count after", v, 8'h01);
        drain("R10", 53, 8'h20);
        drain("R10", 53, 8'h50);
        chk("R10", "dropped cell absent", cell_valid, 0);
        chk("R9", "clav high when empty", tx_clav, 1);
        reg_read(2'd2, v);
        chk("R10", "overflow is not a runt", v, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cfg_readback();
        t_basic53();
        t_cell52_narrow();
        t_wide();
        t_runt();
        t_depth_overflow();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule